// File: doc/BRIEF.md
# Pipeline Data-Hazard Stall Controller

This block decides, every cycle, whether the instruction sitting in the Decode stage of a five-stage in-order pipeline (Fetch, Decode, Compute, Memory, Write Back) may move on. The pipeline has no forwarding network. An instruction that reads a register still owed by an older instruction in Compute, Memory or Write Back must therefore wait in Decode until that producer has written the register file. The register file does not pass a same-cycle write through to a read.

Each cycle the controller compares the source register numbers of the Decode instruction with the destination number and write-enable of every downstream stage. On a match it freezes the program counter and the Fetch/Decode buffer, so neither the held instruction nor the one being fetched is lost. In the same cycle it tells the Decode/Compute buffer to load a no-operation instead of the held instruction. The producer keeps moving, and each inserted bubble idles Compute, Memory and Write Back in turn. The decision is purely combinational. The clock and reset only serve a small run-length counter used by the built-in checks.

Top module: `hz_stall_ctrl`

## Requirements
- R1: A stall is raised in the same cycle when either Decode source equals the Compute-stage destination and the Compute write-enable is set. Source k occupies bits [k*AW +: AW] of `dec_src_i`. Stage 0 (Compute), 1 (Memory) and 2 (Write Back) occupy slot s of `stg_dst_i` and bit s of `stg_we_i`.
- R2: A stall is raised when a Decode source equals the Memory-stage destination with its write-enable set.
- R3: A stall is raised when a Decode source equals the Write Back destination with its write-enable set. The consumer is released in the cycle after the producer leaves Write Back.
- R4: Register number 0 never causes a stall, even when a downstream stage writes register 0.
- R5: A downstream instruction with its write-enable clear, such as a store or branch, never causes a stall, whatever its destination field holds.
- R6: `pc_hold_o`, `fd_hold_o` and `dc_bubble_o` are always equal. All three are low when there is no hazard, including straight after reset.
- R7: A consumer held by one producer is held for 4-d cycles at dependency distance d = 1, 2 or 3. It is not held at distance 4 or more.
- R8: A match on the second source alone stalls exactly as a match on the first source does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the run-length counter |
| rst_ni | input | 1 | Active-low asynchronous reset |
| dec_src_i | input | NUM_SRC*AW | Source register numbers of the Decode instruction |
| stg_dst_i | input | NUM_DOWN*AW | Destination numbers of Compute, Memory and Write Back |
| stg_we_i | input | NUM_DOWN | Register write-enables of the same stages |
| pc_hold_o | output | 1 | Freeze the program counter |
| fd_hold_o | output | 1 | Keep the Fetch/Decode buffer contents |
| dc_bubble_o | output | 1 | Load a no-operation into the Decode/Compute buffer |

## Verification
The outputs are combinational, so a wrong comparison shows at the ports in the same cycle it happens. A dropped stall lets a consumer leave Decode one or more cycles early. A spurious stall inserts an extra bubble and delays every later instruction by one cycle. The bench runs a scoreboard copy of the pipeline slots and compares all three outputs with the expected stall on every cycle. It also counts the held cycles of each directed dependency. A stage comparison that is missing or misrouted therefore shows as a wrong count within four cycles of the consumer reaching Decode.

// File: rtl/hz_pkg.sv
package hz_pkg;
  // Downstream stages compared against Decode, in pipeline order.
  typedef enum logic [1:0] {
    STG_COMPUTE = 2'd0,
    STG_MEMORY  = 2'd1,
    STG_WRBACK  = 2'd2
  } down_stage_e;

  localparam int unsigned DOWN_STAGES = 3;
  localparam int unsigned SRC_PORTS   = 2;
  localparam int unsigned REG_AW      = 5;
endpackage

// File: rtl/hz_src_cmp.sv
module hz_src_cmp #(
  parameter int unsigned AW       = 5,
  parameter int unsigned NUM_DOWN = 3
) (
  input  logic [AW-1:0]          src_i,
  input  logic [NUM_DOWN*AW-1:0] dst_i,
  input  logic [NUM_DOWN-1:0]    we_i,
  output logic [NUM_DOWN-1:0]    hit_o
);
  logic src_live;
  assign src_live = |src_i;  // register 0 is hardwired

  for (genvar g = 0; g < NUM_DOWN; g++) begin : g_stage
    assign hit_o[g] = src_live && we_i[g] && (dst_i[g*AW +: AW] == src_i);
  end
endmodule

// File: rtl/hz_stall_gen.sv
module hz_stall_gen #(
  parameter int unsigned NUM_SRC  = 2,
  parameter int unsigned NUM_DOWN = 3
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [NUM_SRC*NUM_DOWN-1:0] hit_i,
  output logic                        stall_o
);
  localparam int unsigned CW = $clog2(NUM_DOWN + 2);

  logic [CW-1:0] run_q;

  assign stall_o = |hit_i;

  // consecutive held cycles, saturating
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      run_q <= '0;
    else if (!stall_o)                run_q <= '0;
    else if (run_q != {CW{1'b1}})     run_q <= run_q + 1'b1;
  end

  // R7
  stall_run_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q <= CW'(NUM_DOWN));
endmodule

// File: rtl/hz_stall_ctrl.sv
module hz_stall_ctrl #(
  parameter int unsigned AW       = hz_pkg::REG_AW,
  parameter int unsigned NUM_SRC  = hz_pkg::SRC_PORTS,
  parameter int unsigned NUM_DOWN = hz_pkg::DOWN_STAGES
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [NUM_SRC*AW-1:0]  dec_src_i,
  input  logic [NUM_DOWN*AW-1:0] stg_dst_i,
  input  logic [NUM_DOWN-1:0]    stg_we_i,
  output logic                   pc_hold_o,
  output logic                   fd_hold_o,
  output logic                   dc_bubble_o
);
  localparam int unsigned HW = NUM_SRC * NUM_DOWN;

  logic [HW-1:0] hit;
  logic          stall;

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    hz_src_cmp #(.AW(AW), .NUM_DOWN(NUM_DOWN)) i_cmp (
      .src_i (dec_src_i[s*AW +: AW]),
      .dst_i (stg_dst_i),
      .we_i  (stg_we_i),
      .hit_o (hit[s*NUM_DOWN +: NUM_DOWN])
    );
  end

  hz_stall_gen #(.NUM_SRC(NUM_SRC), .NUM_DOWN(NUM_DOWN)) i_gen (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .hit_i   (hit),
    .stall_o (stall)
  );

  assign pc_hold_o   = stall;
  assign fd_hold_o   = stall;
  assign dc_bubble_o = stall;

  // R4
  zero_src_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_src_i == '0) |-> !fd_hold_o);

  // R5
  no_writer_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stg_we_i == '0) |-> !pc_hold_o);

  // R6
  held_src_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fd_hold_o |=> $stable(dec_src_i));

  // R6
  bubble_lands_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dc_bubble_o |=> !stg_we_i[0]);
endmodule

// File: tb/test_hz_stall_ctrl.sv
module test_hz_stall_ctrl;
  localparam int AW = 5;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [2*AW-1:0] dec_src_i = '0;
  logic [3*AW-1:0] stg_dst_i = '0;
  logic [2:0]      stg_we_i  = '0;
  logic pc_hold, fd_hold, dc_bubble;

  always #4 clk = ~clk;

  hz_stall_ctrl i_hz_stall_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .dec_src_i(dec_src_i), .stg_dst_i(stg_dst_i),
    .stg_we_i(stg_we_i), .pc_hold_o(pc_hold), .fd_hold_o(fd_hold), .dc_bubble_o(dc_bubble)
  );

  int checks = 0, fails = 0;
  bit done = 1'b0;

  // program and scoreboard slots
  logic [4:0] p_dst[0:511], p_s1[0:511], p_s2[0:511];
  logic       p_we[0:511];
  int p_len, pc;
  logic [4:0] d_s1, d_s2, ex_dst, mem_dst, wb_dst;
  logic       ex_we, mem_we, wb_we, d_we;
  logic [4:0] d_dst;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit hit(input logic [4:0] s, input logic [4:0] d, input logic w);
    return (s != 0) && w && (s == d);
  endfunction

  function automatic bit exp_stall();
    return hit(d_s1, ex_dst, ex_we) || hit(d_s2, ex_dst, ex_we) ||
           hit(d_s1, mem_dst, mem_we) || hit(d_s2, mem_dst, mem_we) ||
           hit(d_s1, wb_dst, wb_we) || hit(d_s2, wb_dst, wb_we);
  endfunction

  function automatic string tag();
    if (hit(d_s1, ex_dst, ex_we) || hit(d_s2, ex_dst, ex_we)) return "R1";
    if (hit(d_s1, mem_dst, mem_we) || hit(d_s2, mem_dst, mem_we)) return "R2";
    if (hit(d_s1, wb_dst, wb_we) || hit(d_s2, wb_dst, wb_we)) return "R3";
    if (d_s1 == 0 || d_s2 == 0) return "R4";
    return "R5";
  endfunction

  task automatic clear_pipe();
    {d_s1, d_s2, d_dst, d_we} = '0;
    {ex_dst, ex_we, mem_dst, mem_we, wb_dst, wb_we} = '0;
    pc = 0;
  endtask

  task automatic fetch();
    if (pc < p_len) begin
      d_s1 = p_s1[pc]; d_s2 = p_s2[pc]; d_dst = p_dst[pc]; d_we = p_we[pc];
    end else begin
      {d_s1, d_s2, d_dst, d_we} = '0;
    end
    pc++;
  endtask

  task automatic step(output bit st);
    bit e;
    @(negedge clk);
    dec_src_i = {d_s2, d_s1};
    stg_dst_i = {wb_dst, mem_dst, ex_dst};
    stg_we_i  = {wb_we, mem_we, ex_we};
    #2;
    e = exp_stall();
    chk(fd_hold == e, tag(), fd_hold, e);
    chk(pc_hold == fd_hold && dc_bubble == fd_hold, "R6", {pc_hold, dc_bubble}, {fd_hold, fd_hold});
    st = e;
    @(posedge clk); #1;
    wb_dst = mem_dst; wb_we = mem_we;
    mem_dst = ex_dst; mem_we = ex_we;
    if (e) begin ex_dst = '0; ex_we = 1'b0; end
    else begin ex_dst = d_dst; ex_we = d_we; fetch(); end
  endtask

  task automatic put(input int i, input logic [4:0] dst, input logic we,
                     input logic [4:0] s1, input logic [4:0] s2);
    p_dst[i] = dst; p_we[i] = we; p_s1[i] = s1; p_s2[i] = s2;
  endtask

  // producer writes 'pdst' (we=pwe), then d-1 fillers, then consumer reading 'cs'
  task automatic dep_run(input int d, input logic [4:0] pdst, input logic pwe,
                         input bit use_s2, input logic [4:0] cs, output int n);
    bit st;
    put(0, pdst, pwe, 5'd0, 5'd0);
    for (int i = 1; i < d; i++) put(i, 5'(20 + i), 1'b1, 5'd0, 5'd0);
    if (use_s2) put(d, 5'd9, 1'b1, 5'd0, cs);
    else        put(d, 5'd9, 1'b1, cs, 5'd0);
    p_len = d + 1;
    clear_pipe();
    fetch();
    n = 0;
    for (int c = 0; c < 16; c++) begin step(st); if (st) n++; end
  endtask

  initial begin
    int n;
    bit st;
    void'($urandom(32'd1234));
    #20 rst_n = 1'b1;
    @(negedge clk); #1;
    // R6 reset state, nothing in flight
    chk(!pc_hold && !fd_hold && !dc_bubble, "R6", {pc_hold, fd_hold, dc_bubble}, 0);

    // R7 distances, R1 R2 R3 exercised per cycle inside
    for (int d = 1; d <= 4; d++) begin
      dep_run(d, 5'd5, 1'b1, 1'b0, 5'd5, n);
      chk(n == ((d < 4) ? 4 - d : 0), "R7", n, (d < 4) ? 4 - d : 0);
    end
    // R8 second source
    dep_run(1, 5'd7, 1'b1, 1'b1, 5'd7, n);
    chk(n == 3, "R8", n, 3);
    dep_run(2, 5'd7, 1'b1, 1'b1, 5'd7, n);
    chk(n == 2, "R8", n, 2);
    // R4 register 0
    dep_run(1, 5'd0, 1'b1, 1'b0, 5'd0, n);
    chk(n == 0, "R4", n, 0);
    // R5 store-like producer
    dep_run(1, 5'd5, 1'b0, 1'b0, 5'd5, n);
    chk(n == 0, "R5", n, 0);
    // R3 release timing: distance 3 holds only on the Write Back match
    dep_run(3, 5'd12, 1'b1, 1'b0, 5'd12, n);
    chk(n == 1, "R3", n, 1);

    // random stream over a small register set
    p_len = 400;
    for (int i = 0; i < p_len; i++)
      put(i, 5'($urandom_range(0, 7)), 1'($urandom_range(0, 1)),
          5'($urandom_range(0, 7)), 5'($urandom_range(0, 7)));
    clear_pipe();
    fetch();
    while (pc <= p_len + 4) step(st);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule